// File: doc/BRIEF.md
# Double-Buffered Isochronous OUT Receive FIFO

This block is the receive half of an isochronous host-to-device endpoint. It has two packet buffers. The bus side fills one buffer at a time with bytes. The processor side empties the other buffer through a one-byte read port. A packet is closed by an end strobe together with a good flag, which reports that the packet passed the upstream error check. A closed, good packet hands its buffer over to the reader and swaps the fill side to the other buffer.

A single service flag tells the processor that at least one complete, checked packet is waiting. A waiting packet can be full size, short or empty. The flag stays up until every held byte in both buffers has been read out. The processor reads a byte count for the oldest held packet. It then pops bytes one at a time. An empty packet is released with an acknowledge pulse.

Top module: `iso_out_rx_fifo`

## Requirements
- R1: `rx_service` becomes 1 one cycle after the edge that closes a good packet.
- R2: A packet holds at most `PKT_MAX` bytes. If a packet brings more bytes than that, the whole packet is discarded.
- R3: Short packets and zero-length packets set `rx_service`. A zero-length packet reports a count of 0.
- R4: `rx_service` stays 1 while either buffer holds a packet. It drops only when both buffers have been released.
- R5: A packet closed with `rx_good` = 0 is discarded. It fills no buffer, and the next packet reuses that same buffer.
- R6: While both buffers hold packets, an incoming packet (including a zero-length one) is dropped. The held packets are left unchanged.
- R7: `rd_cnt` shows the stored byte count of the oldest held packet, or 0 when none is held. Packets are read in the order they arrived.
- R8: `rd_data` presents the next unread byte of the oldest packet. Each `rd_en` cycle advances by one byte. Reading the last byte releases the buffer.
- R9: When no byte is available (no packet is held, or the oldest packet is zero-length), `rd_en` has no effect and `rd_data` reads 0.
- R10: `rd_ack` releases an oldest packet that is zero-length. When the oldest packet has bytes, `rd_ack` is ignored.
- R11: After reset both buffers are empty, `rx_service` is 0, and `rd_cnt` and `rd_data` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A data byte is present on `rx_data` this cycle |
| rx_data | input | DW | Incoming byte |
| rx_end | input | 1 | Packet ends this cycle. A byte present in the same cycle is the packet's last byte |
| rx_good | input | 1 | Sampled with `rx_end`: 1 means the packet passed its error check |
| rd_en | input | 1 | Pop one byte from the oldest packet |
| rd_ack | input | 1 | Release the oldest packet if it is zero-length |
| rd_data | output | DW | Next byte of the oldest packet, 0 if none |
| rd_cnt | output | $clog2(PKT_MAX+1) | Byte count of the oldest packet, 0 if none |
| rx_service | output | 1 | At least one complete good packet is held |

## Verification
The bench builds the block with `PKT_MAX` = 8 and the default 8-bit data width. The short buffer makes oversized packets and a full-size packet take only a few cycles. It also means both buffers fill often during long randomised traffic. As a result, dropping packets while both buffers are full, releasing one buffer in the same edge as a new byte arrives, and the exact size boundary are each hit many times against the reference model.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
    localparam int unsigned NBUF = 2;
    typedef logic [NBUF-1:0] buf_mask_t;
endpackage

// File: rtl/iso_rx_store.sv
module iso_rx_store #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/iso_rx_fill.sv
module iso_rx_fill
    import iso_rx_pkg::*;
#(
    parameter int unsigned PKT_MAX = 256,
    localparam int unsigned CW     = $clog2(PKT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_end,
    input  logic          rx_good,
    input  buf_mask_t     full_mask,
    output logic          we,
    output logic          wsel,
    output logic [CW-1:0] woff,
    output logic          done,
    output logic [CW-1:0] done_cnt
);
    typedef struct packed {
        logic          sel;
        logic [CW-1:0] wcnt;
        logic          err;
    } fill_st_t;

    fill_st_t q, d;
    logic cur_full, byte_err, err_now;

    always_comb begin
        d        = q;
        cur_full = full_mask[q.sel];
        byte_err = rx_valid && (cur_full || q.wcnt == CW'(PKT_MAX));
        we       = rx_valid && !byte_err;
        err_now  = q.err || byte_err || cur_full;
        done     = rx_end && rx_good && !err_now;
        done_cnt = q.wcnt + CW'(we);
        if (we)       d.wcnt = q.wcnt + CW'(1);
        if (byte_err) d.err  = 1'b1;
        if (rx_end) begin
            d.wcnt = '0;
            d.err  = 1'b0;
            if (done) d.sel = ~q.sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wsel = q.sel;
    assign woff = q.wcnt;

    AST_WCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.wcnt <= CW'(PKT_MAX)); // R2
endmodule

// File: rtl/iso_rx_drain.sv
module iso_rx_drain
    import iso_rx_pkg::*;
#(
    parameter int unsigned PKT_MAX = 256,
    localparam int unsigned CW     = $clog2(PKT_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  buf_mask_t                full_mask,
    input  logic [NBUF-1:0][CW-1:0]  cnt_tab,
    input  logic                     rd_en,
    input  logic                     rd_ack,
    output logic                     rsel,
    output logic [CW-1:0]            roff,
    output logic                     rel
);
    typedef struct packed {
        logic          sel;
        logic [CW-1:0] rptr;
    } drain_st_t;

    drain_st_t q, d;
    logic          head_full, pop, ack, last;
    logic [CW-1:0] head_cnt;

    always_comb begin
        d         = q;
        head_full = full_mask[q.sel];
        head_cnt  = cnt_tab[q.sel];
        pop       = rd_en && head_full && head_cnt != '0;
        ack       = rd_ack && head_full && head_cnt == '0;
        last      = pop && (q.rptr + CW'(1) == head_cnt);
        rel       = last || ack;
        if (pop) d.rptr = q.rptr + CW'(1);
        if (rel) begin
            d.rptr = '0;
            d.sel  = ~q.sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsel = q.sel;
    assign roff = q.rptr;

    AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !full_mask[q.sel]) |=> $stable(q.rptr) && $stable(q.sel)); // R9
    AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !rd_en && cnt_tab[q.sel] != '0) |=> $stable(q.rptr) && $stable(q.sel)); // R10
endmodule

// File: rtl/iso_out_rx_fifo.sv
module iso_out_rx_fifo
    import iso_rx_pkg::*;
#(
    parameter int unsigned PKT_MAX = 256,
    parameter int unsigned DW      = 8,
    localparam int unsigned CW     = $clog2(PKT_MAX + 1),
    localparam int unsigned DEPTH  = NBUF * PKT_MAX,
    localparam int unsigned AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_end,
    input  logic          rx_good,
    input  logic          rd_en,
    input  logic          rd_ack,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] rd_cnt,
    output logic          rx_service
);
    typedef struct packed {
        buf_mask_t               full;
        logic [NBUF-1:0][CW-1:0] cnt;
    } top_st_t;

    top_st_t q, d;

    logic          we, wsel, done, rsel, rel;
    logic [CW-1:0] woff, done_cnt, roff;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] mem_rdata;
    logic          head_bytes;

    iso_rx_fill #(.PKT_MAX(PKT_MAX)) u_fill (
        .clk, .rst_n, .rx_valid, .rx_end, .rx_good,
        .full_mask(q.full), .we, .wsel, .woff, .done, .done_cnt
    );

    iso_rx_drain #(.PKT_MAX(PKT_MAX)) u_drain (
        .clk, .rst_n, .full_mask(q.full), .cnt_tab(q.cnt),
        .rd_en, .rd_ack, .rsel, .roff, .rel
    );

    assign waddr = AW'(wsel) * AW'(PKT_MAX) + AW'(woff);
    assign raddr = AW'(rsel) * AW'(PKT_MAX) + AW'(roff);

    iso_rx_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk, .we, .waddr, .wdata(rx_data), .raddr, .rdata(mem_rdata)
    );

    always_comb begin
        d = q;
        if (rel) d.full[rsel] = 1'b0;
        if (done) begin
            d.full[wsel] = 1'b1;
            d.cnt[wsel]  = done_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head_bytes = q.full[rsel] && q.cnt[rsel] != '0;
    assign rx_service = |q.full;
    assign rd_cnt     = q.full[rsel] ? q.cnt[rsel] : '0;
    assign rd_data    = head_bytes ? mem_rdata : '0;

    AST_FILL_RAISES_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_service); // R1
    AST_SERVICE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_service && !rel) |=> rx_service); // R4
    AST_WRITE_TO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !q.full[wsel]); // R6
    AST_BAD_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && !rx_good) |=> ((q.full & ~$past(q.full)) == '0)); // R5
endmodule

// File: tb/sim_iso_out_rx_fifo.sv
module sim_iso_out_rx_fifo;
    localparam int PKT = 8;
    localparam int CW  = $clog2(PKT + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0, rx_end = 1'b0, rx_good = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rd_en = 1'b0, rd_ack = 1'b0;
    logic [7:0]    rd_data;
    logic [CW-1:0] rd_cnt;
    logic          rx_service;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    iso_out_rx_fifo #(.PKT_MAX(PKT), .DW(8)) u0 (
        .clk, .rst_n, .rx_valid, .rx_data, .rx_end, .rx_good,
        .rd_en, .rd_ack, .rd_data, .rd_cnt, .rx_service
    );

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // reference model: held packets as a flat byte queue plus count queue
    logic [7:0] bq[$];
    int         cntq[$];
    logic [7:0] cur[$];
    int         rdidx;
    bit         merr;

    always @(posedge clk) begin
        bit fullpre;
        if (!rst_n) begin
            bq.delete(); cntq.delete(); cur.delete();
            rdidx = 0; merr = 1'b0;
        end else begin
            fullpre = (cntq.size() == 2);
            if (cntq.size() > 0) begin
                if (rd_en && cntq[0] > 0) begin
                    void'(bq.pop_front());
                    rdidx++;
                    if (rdidx == cntq[0]) begin
                        void'(cntq.pop_front());
                        rdidx = 0;
                    end
                end else if (rd_ack && cntq[0] == 0) begin
                    void'(cntq.pop_front());
                end
            end
            if (rx_valid) begin
                if (fullpre || cur.size() >= PKT) merr = 1'b1;
                else cur.push_back(rx_data);
            end
            if (rx_end) begin
                if (rx_good && !merr && !fullpre) begin
                    foreach (cur[i]) bq.push_back(cur[i]);
                    cntq.push_back(cur.size());
                end
                cur.delete();
                merr = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1/R4 rx_service vs model", int'(rx_service), int'(cntq.size() > 0));
            chk("R7 rd_cnt vs model", int'(rd_cnt), (cntq.size() > 0) ? cntq[0] : 0);
            chk("R8 rd_data vs model", int'(rd_data),
                (cntq.size() > 0 && cntq[0] > 0) ? int'(bq[0]) : 0);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_pkt(int n, bit good, int base);
        if (n == 0) begin
            rx_end = 1'b1; rx_good = good;
            @(negedge clk);
        end else begin
            for (int i = 0; i < n; i++) begin
                rx_valid = 1'b1;
                rx_data  = 8'(base + i);
                rx_end   = (i == n - 1);
                rx_good  = good;
                @(negedge clk);
            end
        end
        rx_valid = 1'b0; rx_end = 1'b0; rx_good = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_n(int n);
        rd_en = 1'b1;
        repeat (n) @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ack();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset rx_service", int'(rx_service), 0);
        chk("R11 reset rd_cnt", int'(rd_cnt), 0);
        chk("R11 reset rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        idle(2);

        // full-size packet
        send_pkt(PKT, 1'b1, 'h10);
        chk("R1 service after full packet", int'(rx_service), 1);
        chk("R2 full-size count", int'(rd_cnt), PKT);
        chk("R8 first byte", int'(rd_data), 'h10);
        read_n(PKT);
        chk("R8 release after last byte", int'(rx_service), 0);

        // short then zero-length
        send_pkt(3, 1'b1, 'h20);
        send_pkt(0, 1'b1, 0);
        chk("R3 short packet count", int'(rd_cnt), 3);
        read_n(3);
        chk("R3 zero-length count", int'(rd_cnt), 0);
        chk("R3 zero-length sets service", int'(rx_service), 1);
        read_n(2);
        chk("R9 rd_en on zero-length no effect", int'(rx_service), 1);
        chk("R9 rd_data on zero-length", int'(rd_data), 0);
        ack();
        chk("R10 ack releases zero-length", int'(rx_service), 0);

        // bad packet then reuse
        send_pkt(4, 1'b0, 'h30);
        chk("R5 bad packet no service", int'(rx_service), 0);
        send_pkt(2, 1'b1, 'h40);
        chk("R5 buffer reused data", int'(rd_data), 'h40);
        chk("R5 buffer reused count", int'(rd_cnt), 2);
        read_n(2);

        // two packets, clear only after both drained
        send_pkt(5, 1'b1, 'h50);
        send_pkt(6, 1'b1, 'h60);
        read_n(5);
        chk("R4 service held after first drained", int'(rx_service), 1);
        chk("R7 second count", int'(rd_cnt), 6);
        read_n(6);
        chk("R4 service clears after both", int'(rx_service), 0);

        // both full: further packets dropped
        send_pkt(2, 1'b1, 'h70);
        send_pkt(3, 1'b1, 'h78);
        send_pkt(4, 1'b1, 'h7C);
        send_pkt(0, 1'b1, 0);
        chk("R6 oldest count kept", int'(rd_cnt), 2);
        chk("R7 oldest byte first", int'(rd_data), 'h70);
        read_n(2);
        chk("R6 second kept count", int'(rd_cnt), 3);
        chk("R6 second kept data", int'(rd_data), 'h78);
        read_n(3);
        chk("R6 dropped packets absent", int'(rx_service), 0);

        // oversize
        send_pkt(PKT + 1, 1'b1, 'h90);
        chk("R2 oversize discarded", int'(rx_service), 0);

        // ack ignored on non-empty head
        send_pkt(3, 1'b1, 'hA0);
        ack();
        chk("R10 ack ignored count", int'(rd_cnt), 3);
        chk("R10 ack ignored data", int'(rd_data), 'hA0);
        read_n(3);

        // empty read
        read_n(2);
        chk("R9 empty read data", int'(rd_data), 0);
        chk("R9 empty read service", int'(rx_service), 0);
        send_pkt(2, 1'b1, 'hB0);
        chk("R9 pointer unmoved", int'(rd_data), 'hB0);
        read_n(2);

        // randomised traffic against the model
        for (int c = 0; c < 4000; c++) begin
            rx_valid = ($urandom % 3) != 0;
            rx_data  = 8'($urandom);
            rx_end   = ($urandom % 6) == 0;
            rx_good  = ($urandom % 5) != 0;
            rd_en    = ($urandom % 2) != 0;
            rd_ack   = ($urandom % 4) == 0;
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_end = 1'b0; rd_en = 1'b0; rd_ack = 1'b0;
        idle(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule